// File: doc/BRIEF.md
# Critical-Word-First Line Transfer

This block returns one cache line from a second-level cache bank to a requester over a datapath narrower than the line. With the default sizes, a 32-byte line is split into four 64-bit doublewords, and each one travels as one beat. The requester gives a line address and the index of the doubleword it needs first. The block sends that doubleword in the first beat. The rest of the line follows in wrapping order, so the requester can restart as soon as the first beat arrives.

Every beat carries its own doubleword index. A flag marks the first beat as the critical one, and another flag marks the final beat. The bank is occupied for exactly one beat per doubleword, on consecutive cycles. While a line is in flight the block drops its ready signal and ignores new requests. The bank storage is a plain array with a fill port that writes one doubleword at a time. Arbitration and tag lookup happen elsewhere.

Top module: `cwf_line_xfer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `beat_valid` is 0 and `req_ready` is 1; a reset during a transfer abandons it.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. The first beat appears in the following cycle, and `beat_valid` stays 1 for exactly four consecutive cycles.
- R3: The first beat of a transfer carries `beat_dw` equal to the requested `req_dw`.
- R4: Beat k (k = 0..3) carries `beat_dw` = (`req_dw` + k) mod 4, so indices wrap from 3 to 0.
- R5: On every beat, `beat_data` equals the doubleword stored at the requested line and at index `beat_dw`. Doubleword d occupies bytes 8d..8d+7 of the line.
- R6: `beat_crit` is 1 on the first beat of a transfer and 0 in every other cycle.
- R7: `beat_last` is 1 on the fourth beat of a transfer and 0 in every other cycle.
- R8: `req_ready` is 0 in every cycle where `beat_valid` is 1. A request presented during a transfer is ignored: the beats keep the original line and order, and no transfer follows it.
- R9: A fill with `fill_en` = 1 writes `fill_data` at (`fill_line`, `fill_dw`) on the clock edge. Later transfers return the new value at that position and the old values at the line's other doublewords.
- R10: In the cycle after the last beat, `beat_valid` is 0 and `req_ready` is 1. The block is then idle until the next request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Write one doubleword into the bank |
| fill_line | input | 4 | Line address for the fill |
| fill_dw | input | 2 | Doubleword index for the fill |
| fill_data | input | 64 | Fill data |
| req_valid | input | 1 | Line request present |
| req_ready | output | 1 | Block can take a request |
| req_line | input | 4 | Requested line address |
| req_dw | input | 2 | Index of the doubleword needed first |
| beat_valid | output | 1 | A beat is on the output this cycle |
| beat_data | output | 64 | Beat payload |
| beat_dw | output | 2 | Doubleword index of this beat |
| beat_crit | output | 1 | First (critical) beat |
| beat_last | output | 1 | Final beat of the line |

## Verification
A beat counter stuck at the wrong value or a corrupted start index shows up within one beat: the first-beat index differs from the request, or a later index breaks the +1-modulo-4 step. The flags also move off the first or fourth beat. A sequencer that leaves its transfer state too early or too late changes the run length of `beat_valid`. It also makes `req_ready` overlap a beat, which is visible at the latest in the cycle after the expected last beat. A wrong latched line address or a bad lane select appears as data that does not match the stored doubleword on the very beat concerned.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_XFER = 1'b1
   } seq_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cwf_lane_store.sv
module cwf_lane_store #(
   parameter int unsigned LINES  = 16,
   parameter int unsigned DATA_W = 64,
   localparam int unsigned LA_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [LA_W-1:0]   wr_line,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LA_W-1:0]   rd_line,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem_q [LINES];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_q[wr_line] <= wr_data;
      end
   end

   assign rd_data = mem_q[rd_line];

endmodule

// File: rtl/cwf_order_gen.sv
module cwf_order_gen #(
   parameter int unsigned BEATS = 4,
   localparam int unsigned IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic [IDX_W-1:0] base,
   input  logic [IDX_W-1:0] step,
   output logic [IDX_W-1:0] idx
);

   if (cwf_pkg::is_pow2(BEATS)) begin : g_pow2
      // Power-of-two beat count: wrap falls out of the truncated adder.
      assign idx = base + step;
   end else begin : g_mod
      logic [IDX_W:0] sum;
      always_comb begin
         sum = {1'b0, base} + {1'b0, step};
         if (sum >= (IDX_W+1)'(BEATS)) begin
            sum = sum - (IDX_W+1)'(BEATS);
         end
      end
      assign idx = sum[IDX_W-1:0];
   end

endmodule

// File: rtl/cwf_sequencer.sv
module cwf_sequencer #(
   parameter int unsigned BEATS = 4,
   parameter int unsigned LA_W  = 4,
   localparam int unsigned IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1,
   localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(BEATS - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [LA_W-1:0]  req_line,
   input  logic [IDX_W-1:0] req_dw,
   output logic             ready,
   output logic             active,
   output logic             first,
   output logic             last,
   output logic [IDX_W-1:0] step,
   output logic [IDX_W-1:0] base,
   output logic [LA_W-1:0]  line
);

   cwf_pkg::seq_state_e state_q;
   logic [IDX_W-1:0]    cnt_q;
   logic [IDX_W-1:0]    base_q;
   logic [LA_W-1:0]     line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= cwf_pkg::SEQ_IDLE;
         cnt_q   <= '0;
         base_q  <= '0;
         line_q  <= '0;
      end else begin
         unique case (state_q)
            cwf_pkg::SEQ_IDLE: begin
               if (req_valid) begin
                  state_q <= cwf_pkg::SEQ_XFER;
                  cnt_q   <= '0;
                  base_q  <= req_dw;
                  line_q  <= req_line;
               end
            end
            cwf_pkg::SEQ_XFER: begin
               if (cnt_q == LAST_CNT) begin
                  state_q <= cwf_pkg::SEQ_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= cwf_pkg::SEQ_IDLE;
         endcase
      end
   end

   assign ready  = (state_q == cwf_pkg::SEQ_IDLE);
   assign active = (state_q == cwf_pkg::SEQ_XFER);
   assign first  = active && (cnt_q == '0);
   assign last   = active && (cnt_q == LAST_CNT);
   assign step   = cnt_q;
   assign base   = base_q;
   assign line   = line_q;

endmodule

// File: rtl/cwf_line_xfer.sv
module cwf_line_xfer #(
   parameter int unsigned LINE_BYTES = 32,
   parameter int unsigned BEAT_BITS  = 64,
   parameter int unsigned NUM_LINES  = 16,
   localparam int unsigned BEATS = (LINE_BYTES * 8) / BEAT_BITS,
   localparam int unsigned IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1,
   localparam int unsigned LA_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fill_en,
   input  logic [LA_W-1:0]      fill_line,
   input  logic [IDX_W-1:0]     fill_dw,
   input  logic [BEAT_BITS-1:0] fill_data,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [LA_W-1:0]      req_line,
   input  logic [IDX_W-1:0]     req_dw,
   output logic                 beat_valid,
   output logic [BEAT_BITS-1:0] beat_data,
   output logic [IDX_W-1:0]     beat_dw,
   output logic                 beat_crit,
   output logic                 beat_last
);

   // Elaboration-time parameter checks
   if (BEAT_BITS == 0 || (BEAT_BITS % 8) != 0) begin : g_bad_beat
      $error("BEAT_BITS must be a nonzero multiple of 8");
   end
   if (((LINE_BYTES * 8) % BEAT_BITS) != 0) begin : g_bad_split
      $error("line size must be a whole number of beats");
   end
   if (BEATS < 2) begin : g_bad_beats
      $error("a line must take at least two beats");
   end
   if (NUM_LINES < 2) begin : g_bad_lines
      $error("NUM_LINES must be at least 2");
   end

   logic             seq_active;
   logic             seq_first;
   logic             seq_last;
   logic [IDX_W-1:0] seq_step;
   logic [IDX_W-1:0] seq_base;
   logic [LA_W-1:0]  seq_line;
   logic [IDX_W-1:0] cur_idx;

   cwf_sequencer #(
      .BEATS (BEATS),
      .LA_W  (LA_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_line  (req_line),
      .req_dw    (req_dw),
      .ready     (req_ready),
      .active    (seq_active),
      .first     (seq_first),
      .last      (seq_last),
      .step      (seq_step),
      .base      (seq_base),
      .line      (seq_line)
   );

   cwf_order_gen #(
      .BEATS (BEATS)
   ) u_order (
      .base (seq_base),
      .step (seq_step),
      .idx  (cur_idx)
   );

   // One storage lane per doubleword position of the line
   logic [BEAT_BITS-1:0] lane_rd [BEATS];

   for (genvar g = 0; g < BEATS; g++) begin : g_lane
      logic lane_we;
      assign lane_we = fill_en && (fill_dw == IDX_W'(g));

      cwf_lane_store #(
         .LINES  (NUM_LINES),
         .DATA_W (BEAT_BITS)
      ) u_store (
         .clk     (clk),
         .wr_en   (lane_we),
         .wr_line (fill_line),
         .wr_data (fill_data),
         .rd_line (seq_line),
         .rd_data (lane_rd[g])
      );
   end

   assign beat_valid = seq_active;
   assign beat_dw    = seq_active ? cur_idx : '0;
   assign beat_data  = seq_active ? lane_rd[cur_idx] : '0;
   assign beat_crit  = seq_first;
   assign beat_last  = seq_last;

endmodule

// File: rtl/cwf_line_xfer_chk.sv
module cwf_line_xfer_chk #(
   parameter int unsigned BEATS = 4,
   parameter int unsigned IDX_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [IDX_W-1:0] req_dw,
   input logic             beat_valid,
   input logic [IDX_W-1:0] beat_dw,
   input logic             beat_crit,
   input logic             beat_last
);

   logic [IDX_W-1:0] exp_first_q;
   logic [IDX_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_first_q <= '0;
         run_q       <= '0;
      end else begin
         if (req_valid && req_ready) begin
            exp_first_q <= req_dw;
         end
         if (beat_valid) begin
            run_q <= beat_last ? '0 : run_q + 1'b1;
         end
      end
   end

   function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] x);
      return (x == IDX_W'(BEATS - 1)) ? '0 : x + 1'b1;
   endfunction

   AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (beat_valid && beat_crit)); // R2
   AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_last) |=> beat_valid); // R2
   AST_CRIT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      beat_crit |-> (beat_dw == exp_first_q)); // R3
   AST_WRAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_crit) |-> (beat_dw == next_idx($past(beat_dw)))); // R4
   AST_CRIT_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      beat_crit |-> (beat_valid && run_q == '0)); // R6
   AST_LAST_POS: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |-> (beat_valid && run_q == IDX_W'(BEATS - 1))); // R7
   AST_LAST_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && run_q == IDX_W'(BEATS - 1)) |-> beat_last); // R7
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> !req_ready); // R8
   AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_valid |-> req_ready); // R10

endmodule

bind cwf_line_xfer cwf_line_xfer_chk #(
   .BEATS (BEATS),
   .IDX_W (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_dw     (req_dw),
   .beat_valid (beat_valid),
   .beat_dw    (beat_dw),
   .beat_crit  (beat_crit),
   .beat_last  (beat_last)
);

// File: tb/sim_cwf_line_xfer.sv
module sim_cwf_line_xfer;

   localparam int LINES = 16;
   localparam int NB    = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fill_en = 1'b0;
   logic [3:0]  fill_line = '0;
   logic [1:0]  fill_dw = '0;
   logic [63:0] fill_data = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_line = '0;
   logic [1:0]  req_dw = '0;
   logic        beat_valid;
   logic [63:0] beat_data;
   logic [1:0]  beat_dw;
   logic        beat_crit;
   logic        beat_last;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [63:0] model [LINES][NB];

   always #4 clk = ~clk;

   cwf_line_xfer u0 (
      .clk(clk), .rst_n(rst_n),
      .fill_en(fill_en), .fill_line(fill_line), .fill_dw(fill_dw), .fill_data(fill_data),
      .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line), .req_dw(req_dw),
      .beat_valid(beat_valid), .beat_data(beat_data), .beat_dw(beat_dw),
      .beat_crit(beat_crit), .beat_last(beat_last)
   );

   // Stimulus table: {line[3:0], first doubleword[1:0]}
   localparam logic [7:0][5:0] VEC = {
      {4'd0,  2'd0}, {4'd1,  2'd1}, {4'd2,  2'd2}, {4'd3,  2'd3},
      {4'd15, 2'd3}, {4'd9,  2'd2}, {4'd6,  2'd1}, {4'd15, 2'd0}
   };

   function automatic logic [63:0] pat(input int l, input int d);
      return {16'hC0DE, 8'(l), 8'(d), ~32'(l * 37 + d * 5)};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic fill(input int l, input int d, input logic [63:0] v);
      @(negedge clk);
      fill_en = 1'b1; fill_line = 4'(l); fill_dw = 2'(d); fill_data = v;
      @(negedge clk);
      fill_en = 1'b0;
      model[l][d] = v;
   endtask

   // Take a request and check its four beats and the idle cycle after them.
   // When intrude is set, a second request is held up during beats 1..2.
   task automatic xfer(input int l, input int d, input bit intrude);
      int exp_d;
      @(negedge clk);
      chk("R10 ready before request", {63'd0, req_ready}, 64'd1);
      req_valid = 1'b1; req_line = 4'(l); req_dw = 2'(d);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < NB; k++) begin
         exp_d = (d + k) % NB;
         if (k == 0) chk("R3 first index", {62'd0, beat_dw}, 64'(d));
         chk("R2 beat valid", {63'd0, beat_valid}, 64'd1);
         chk("R4 wrap index", {62'd0, beat_dw}, 64'(exp_d));
         chk("R5 beat data", beat_data, model[l][exp_d]);
         chk("R6 crit flag", {63'd0, beat_crit}, (k == 0) ? 64'd1 : 64'd0);
         chk("R7 last flag", {63'd0, beat_last}, (k == NB - 1) ? 64'd1 : 64'd0);
         chk("R8 not ready while busy", {63'd0, req_ready}, 64'd0);
         if (intrude && k == 1) begin
            req_valid = 1'b1; req_line = 4'((l + 5) % LINES); req_dw = 2'((d + 2) % NB);
         end
         if (intrude && k == 3) req_valid = 1'b0;
         if (k < NB - 1) @(negedge clk);
      end
      @(negedge clk);
      chk("R10 idle after last", {63'd0, beat_valid}, 64'd0);
      chk("R10 ready after last", {63'd0, req_ready}, 64'd1);
      if (intrude) begin
         @(negedge clk);
         chk("R8 intruding request dropped", {63'd0, beat_valid}, 64'd0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", {63'd0, beat_valid}, 64'd0);
      chk("R1 ready in reset", {63'd0, req_ready}, 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", {63'd0, beat_valid}, 64'd0);
      chk("R1 ready after reset", {63'd0, req_ready}, 64'd1);

      // R9: load the bank through the fill port
      for (int l = 0; l < LINES; l++)
         for (int d = 0; d < NB; d++)
            fill(l, d, pat(l, d));

      // Table walk: R2..R8, R10
      for (int i = 0; i < 8; i++)
         xfer(int'(VEC[i][5:2]), int'(VEC[i][1:0]), 1'b0);

      // R8: a request held during a transfer is ignored
      xfer(7, 3, 1'b1);

      // R9: overwrite one doubleword, neighbours keep their values
      fill(4, 2, 64'hDEAD_BEEF_0123_4567);
      xfer(4, 1, 1'b0);
      chk("R9 new value kept", model[4][2], 64'hDEAD_BEEF_0123_4567);

      // Back-to-back requests after the idle cycle
      xfer(10, 2, 1'b0);
      xfer(11, 3, 1'b0);

      // R1: reset in the middle of a transfer
      @(negedge clk);
      req_valid = 1'b1; req_line = 4'd5; req_dw = 2'd1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 valid after mid reset", {63'd0, beat_valid}, 64'd0);
      chk("R1 ready after mid reset", {63'd0, req_ready}, 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 stays idle", {63'd0, beat_valid}, 64'd0);
      xfer(5, 1, 1'b0);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule